// File: doc/BRIEF.md
# Processor-side FIFO handshake controller

This block sits in the local system clock domain. It sits between a local processor and a pair of FIFOs: an inbound FIFO that holds words bound for the processor, and an outbound FIFO that takes words from it. The processor starts a transfer by raising a read request or a write request. The block runs one 32-bit transfer for each request, using a four-phase handshake: the request goes up, acknowledge goes up, the request goes down, and acknowledge goes down.

On a read, the controller takes one word from the inbound FIFO. It registers that word on the processor's read-data lines. On a write, it registers the processor's write data and pushes it into the outbound FIFO for one cycle. Every transfer follows the same path: idle, then a single read or write cycle, then acknowledge. The controller stays in acknowledge until the request that started the transfer is lowered.

The inbound FIFO is show-ahead: its head word is on `inData` whenever `inEmpty` is low. The FIFOs themselves are outside this block.

Top module: `proc_fifo_handshake`

## Requirements
- R1: After reset, `ack`, `inPop` and `outPush` are low and `rdData` is all zeros.
- R2: When idle, a read request seen at a clock edge with `inEmpty` low makes `inPop` high for exactly the next cycle.
- R3: `rdData` takes the inbound head word that is present during the `inPop` cycle. It then holds that value through the whole acknowledge phase and after acknowledge falls, until the next read.
- R4: When idle, a write request accepted at a clock edge with `outFull` low makes `outPush` high for exactly the next cycle. During that cycle `outData` carries the `wrData` value sampled at the accepting edge, even if `wrData` changes afterwards.
- R5: `ack` rises on the cycle right after the `inPop` or `outPush` cycle.
- R6: `ack` stays high while the request that started the transfer stays high, whatever the other request does. It falls one cycle after that request is seen low.
- R7: A read request is ignored while `inEmpty` is high, and a write request is ignored while `outFull` is high. Neither strobe pulses, and `ack` stays low.
- R8: If both requests are high in an idle cycle and both can be accepted, the read is served first. If only the write can be accepted, the write is served. `inPop` and `outPush` are never high together.
- R9: Once `ack` has fallen, a new request is accepted with the same timing as the first one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local system clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rdReq | input | 1 | Processor read request |
| wrReq | input | 1 | Processor write request |
| wrData | input | 32 | Processor write word |
| ack | output | 1 | Handshake acknowledge |
| rdData | output | 32 | Registered word read for the processor |
| inData | input | 32 | Head word of the inbound FIFO |
| inEmpty | input | 1 | Inbound FIFO is empty |
| inPop | output | 1 | One-cycle pop strobe to the inbound FIFO |
| outData | output | 32 | Word pushed into the outbound FIFO |
| outFull | input | 1 | Outbound FIFO is full |
| outPush | output | 1 | One-cycle push strobe to the outbound FIFO |

## Verification
The assertions assume a well-behaved processor. Once a request is raised, it stays high until acknowledge is seen, and the processor waits for acknowledge to drop before starting a new transfer. They also assume that the inbound FIFO keeps its head word and its flags steady until a pop has been taken. The stimulus meets these assumptions in three ways. Requests change only on falling edges. Every request is held until the bench has seen `ack`. The bench's FIFO model moves to its next head word only on the falling edge after the capturing edge.

// File: rtl/hs_pkg.sv
package hs_pkg;

  typedef enum logic [1:0] {
    HS_IDLE  = 2'd0,
    HS_READ  = 2'd1,
    HS_WRITE = 2'd2,
    HS_ACK   = 2'd3
  } hsState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capRead;   // load rdData from inbound head
    logic latchWr;   // load outData from processor write word
  } hsStrobe_t;

endpackage

// File: rtl/hs_ctrl.sv
module hs_ctrl
  import hs_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      rdReq,
  input  logic      wrReq,
  input  logic      inEmpty,
  input  logic      outFull,
  output logic      ack,
  output logic      inPop,
  output logic      outPush,
  output hsStrobe_t strobe
);

  hsState_e state, stateNext;
  logic     kindRd, kindRdNext;
  logic     rdOk, wrOk, reqLive;

  assign rdOk    = rdReq && !inEmpty;
  assign wrOk    = wrReq && !outFull;
  assign reqLive = kindRd ? rdReq : wrReq;

  always_comb begin
    stateNext      = state;
    kindRdNext     = kindRd;
    strobe.latchWr = 1'b0;
    unique case (state)
      HS_IDLE: begin
        if (rdOk) begin
          stateNext  = HS_READ;
          kindRdNext = 1'b1;
        end else if (wrOk) begin
          stateNext      = HS_WRITE;
          kindRdNext     = 1'b0;
          strobe.latchWr = 1'b1;
        end
      end
      HS_READ:  stateNext = HS_ACK;
      HS_WRITE: stateNext = HS_ACK;
      HS_ACK: begin
        if (!reqLive) stateNext = HS_IDLE;
      end
      default:  stateNext = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= HS_IDLE;
      kindRd <= 1'b0;
    end else begin
      state  <= stateNext;
      kindRd <= kindRdNext;
    end
  end

  assign strobe.capRead = (state == HS_READ);
  assign inPop          = (state == HS_READ);
  assign outPush        = (state == HS_WRITE);
  assign ack            = (state == HS_ACK);

endmodule

// File: rtl/hs_datapath.sv
module hs_datapath
  import hs_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  hsStrobe_t         strobe,
  input  logic [DATA_W-1:0] inData,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] outData
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData  <= '0;
      outData <= '0;
    end else begin
      if (strobe.capRead) rdData  <= inData;
      if (strobe.latchWr) outData <= wrData;
    end
  end

endmodule

// File: rtl/proc_fifo_handshake.sv
module proc_fifo_handshake
  import hs_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdReq,
  input  logic              wrReq,
  input  logic [DATA_W-1:0] wrData,
  output logic              ack,
  output logic [DATA_W-1:0] rdData,
  input  logic [DATA_W-1:0] inData,
  input  logic              inEmpty,
  output logic              inPop,
  output logic [DATA_W-1:0] outData,
  input  logic              outFull,
  output logic              outPush
);

  hsStrobe_t strobe;

  hs_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .rdReq   (rdReq),
    .wrReq   (wrReq),
    .inEmpty (inEmpty),
    .outFull (outFull),
    .ack     (ack),
    .inPop   (inPop),
    .outPush (outPush),
    .strobe  (strobe)
  );

  hs_datapath #(.DATA_W(DATA_W)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .inData  (inData),
    .wrData  (wrData),
    .rdData  (rdData),
    .outData (outData)
  );

endmodule

// File: rtl/proc_fifo_handshake_chk.sv
module proc_fifo_handshake_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              rdReq,
  input logic              wrReq,
  input logic [DATA_W-1:0] wrData,
  input logic              ack,
  input logic [DATA_W-1:0] rdData,
  input logic              inEmpty,
  input logic              inPop,
  input logic [DATA_W-1:0] outData,
  input logic              outFull,
  input logic              outPush
);

  // remembers which kind of transfer owns the current acknowledge
  logic seenRd;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        seenRd <= 1'b0;
    else if (inPop)   seenRd <= 1'b1;
    else if (outPush) seenRd <= 1'b0;
  end

  p_pop_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    inPop |=> !inPop);

  p_rd_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ack && $past(ack)) |-> $stable(rdData));

  p_push_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    outPush |=> !outPush);

  p_push_data_r4: assert property (@(posedge clk) disable iff (!rstN)
    outPush |-> (outData == $past(wrData)));

  p_ack_follows_r5: assert property (@(posedge clk) disable iff (!rstN)
    (inPop || outPush) |=> ack);

  p_ack_hold_rd_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ack && seenRd && rdReq) |=> ack);

  p_ack_hold_wr_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ack && !seenRd && wrReq) |=> ack);

  p_ack_drop_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ack && (seenRd ? !rdReq : !wrReq)) |=> !ack);

  p_no_pop_empty_r7: assert property (@(posedge clk) disable iff (!rstN)
    inPop |-> $past(rdReq && !inEmpty));

  p_no_push_full_r7: assert property (@(posedge clk) disable iff (!rstN)
    outPush |-> $past(wrReq && !outFull));

  p_strobe_excl_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(inPop && outPush));

  p_read_first_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!ack && !inPop && !outPush && rdReq && wrReq && !inEmpty) |=> inPop);

endmodule

bind proc_fifo_handshake proc_fifo_handshake_chk #(.DATA_W(DATA_W)) chk_i (.*);

// File: tb/proc_fifo_handshake_tb_top.sv
module proc_fifo_handshake_tb_top;

  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         rdReq = 1'b0, wrReq = 1'b0;
  logic [W-1:0] wrData = '0;
  logic         ack, inPop, outPush;
  logic [W-1:0] rdData, outData;
  logic [W-1:0] inData = '0;
  logic         inEmpty = 1'b1;
  logic         outFull = 1'b0;

  int nChk = 0, nFail = 0;
  logic [W-1:0] inQ[$];
  logic [W-1:0] expRd[$];
  logic [W-1:0] expWr[$];
  bit popPend = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  proc_fifo_handshake dut_i (
    .clk(clk), .rstN(rstN), .rdReq(rdReq), .wrReq(wrReq), .wrData(wrData),
    .ack(ack), .rdData(rdData), .inData(inData), .inEmpty(inEmpty),
    .inPop(inPop), .outData(outData), .outFull(outFull), .outPush(outPush)
  );

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic refreshIn();
    inEmpty = (inQ.size() == 0);
    inData  = inEmpty ? '0 : inQ[0];
  endtask

  // inbound FIFO model: drop the head one falling edge after the pop cycle
  always @(negedge clk) begin
    if (popPend) begin
      void'(inQ.pop_front());
      popPend = 1'b0;
    end
    if (inPop) popPend = 1'b1;
    refreshIn();
  end

  // outbound monitor: scoreboard compare of each pushed word
  always @(negedge clk) begin
    if (rstN && outPush) begin
      if (expWr.size() == 0) chk(1'b0, "R4 unexpected push", outData, '0);
      else begin
        logic [W-1:0] e;
        e = expWr.pop_front();
        chk(outData == e, "R4 pushed word", outData, e);
      end
    end
  end

  task automatic loadIn(input logic [W-1:0] w);
    inQ.push_back(w);
    expRd.push_back(w);
    refreshIn();
  endtask

  task automatic doRead(input int hold);
    logic [W-1:0] e;
    @(negedge clk) rdReq = 1'b1;
    @(negedge clk);
    chk(inPop == 1'b1, "R2 pop pulse", {31'b0, inPop}, 1);
    chk(ack == 1'b0, "R5 ack not yet", {31'b0, ack}, 0);
    @(negedge clk);
    e = expRd.pop_front();
    chk(inPop == 1'b0, "R2 pop one cycle", {31'b0, inPop}, 0);
    chk(ack == 1'b1, "R5 ack rises", {31'b0, ack}, 1);
    chk(rdData == e, "R3 read word", rdData, e);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk(ack == 1'b1, "R6 ack held", {31'b0, ack}, 1);
      chk(rdData == e, "R3 word stable", rdData, e);
    end
    rdReq = 1'b0;
    @(negedge clk);
    chk(ack == 1'b0, "R6 ack falls", {31'b0, ack}, 0);
    chk(rdData == e, "R3 word kept", rdData, e);
  endtask

  task automatic doWrite(input logic [W-1:0] w);
    @(negedge clk);
    wrData = w; wrReq = 1'b1;
    expWr.push_back(w);
    @(negedge clk);
    wrData = ~w;   // must not disturb the latched word
    chk(outPush == 1'b1, "R4 push pulse", {31'b0, outPush}, 1);
    @(negedge clk);
    chk(outPush == 1'b0, "R4 push one cycle", {31'b0, outPush}, 0);
    chk(ack == 1'b1, "R5 ack after push", {31'b0, ack}, 1);
    wrReq = 1'b0;
    @(negedge clk);
    chk(ack == 1'b0, "R6 ack falls on write", {31'b0, ack}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(ack == 1'b0 && inPop == 1'b0 && outPush == 1'b0, "R1 reset strobes",
        {29'b0, ack, inPop, outPush}, 0);
    chk(rdData == '0, "R1 reset rdData", rdData, '0);
    rstN = 1'b1;

    // writes with varied patterns
    doWrite(32'hDEAD_BEEF);
    doWrite(32'h0000_0001);
    doWrite(32'hFFFF_FFFF);

    // reads, back to back (R9) and with long hold (R6)
    loadIn(32'h1234_5678);
    loadIn(32'hA5A5_5A5A);
    loadIn(32'h0F0F_F0F0);
    doRead(0);
    doRead(0);   // R9: restart right after ack fell
    doRead(6);

    // R7 read ignored while empty
    @(negedge clk) rdReq = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(!inPop && !ack, "R7 read while empty", {30'b0, inPop, ack}, 0);
    end
    rdReq = 1'b0;

    // R7 write ignored while full
    @(negedge clk) begin outFull = 1'b1; wrReq = 1'b1; wrData = 32'h5555_AAAA; end
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(!outPush && !ack, "R7 write while full", {30'b0, outPush, ack}, 0);
    end
    wrReq = 1'b0;
    @(negedge clk) outFull = 1'b0;

    // R8 both raised: read first; dropping write has no effect (R6)
    loadIn(32'hCAFE_F00D);
    @(negedge clk) begin rdReq = 1'b1; wrReq = 1'b1; wrData = 32'h7777_0000; end
    @(negedge clk);
    chk(inPop && !outPush, "R8 read wins", {30'b0, inPop, outPush}, 2);
    @(negedge clk);
    chk(ack == 1'b1, "R5 ack on tie", {31'b0, ack}, 1);
    chk(rdData == 32'hCAFE_F00D, "R3 tie word", rdData, 32'hCAFE_F00D);
    void'(expRd.pop_front());
    wrReq = 1'b0;
    repeat (2) begin
      @(negedge clk);
      chk(ack == 1'b1, "R6 other request ignored", {31'b0, ack}, 1);
    end
    rdReq = 1'b0;
    @(negedge clk);
    chk(ack == 1'b0, "R6 ack falls after tie", {31'b0, ack}, 0);

    // R8 both raised with inbound empty: write served
    @(negedge clk) begin rdReq = 1'b1; wrReq = 1'b1; wrData = 32'h3C3C_C3C3; end
    expWr.push_back(32'h3C3C_C3C3);
    @(negedge clk);
    chk(outPush && !inPop, "R8 write when read blocked", {30'b0, inPop, outPush}, 1);
    @(negedge clk);
    chk(ack == 1'b1, "R5 ack after fallback write", {31'b0, ack}, 1);
    rdReq = 1'b0;
    @(negedge clk);
    chk(ack == 1'b1, "R6 read drop ignored", {31'b0, ack}, 1);
    wrReq = 1'b0;
    @(negedge clk);
    chk(ack == 1'b0, "R6 ack falls", {31'b0, ack}, 0);

    repeat (3) @(negedge clk);
    chk(expWr.size() == 0, "R4 all pushes seen", expWr.size(), 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
      $finish;
    end
  end

endmodule